// File: doc/BRIEF.md
# Masked Pattern Detector on an Accumulator

This block keeps a registered two's-complement accumulator and compares each new result against a reference pattern. Bits whose mask bit is set are left out of the comparison. Two flags leave the block in the same register stage as the value they describe. The first reports an equality with the pattern. The second reports an equality with the pattern's bitwise complement.

The pattern is either a fixed parameter or the live compare input. The mask is chosen by parameter from one of four sources:

- a fixed value;
- the compare input itself;
- the inverted compare input moved up by one place;
- the inverted compare input moved up by two places.

The two shifted sources serve convergent rounding.

On top of the flags, the block reports when the running value leaves the matching window. It raises overflow when the value climbs out and underflow when it falls out. It can also clear itself on the cycle after a match, or on the cycle after a non-match. This makes it usable as a terminal-count counter or a saturating-detect accumulator.

Top module: `patmatch_acc`

## Requirements
- R1: A synchronous active-high `rst` sets `acc_q` to zero and drops `hit`, `hit_inv`, `ovf` and `unf` at the next rising edge.
- R2: On a rising edge with `en` high and no clear pending, `acc_q` becomes `acc_q + addend`, wrapping modulo 2^W. With `en` low and no clear pending, every output holds its value.
- R3: `hit` is 1 exactly when every bit of the new `acc_q` whose mask bit is 0 equals the pattern bit. A mask bit of 1 excludes that position. The pattern and mask are taken from `cmp_in` at the same edge that loads `acc_q`.
- R4: With `PAT_SRC = PAT_STATIC`, the pattern is `PATTERN_VAL`. With `PAT_DYN`, it is `cmp_in`. The defaults are an all-zero pattern and an all-ones mask.
- R5: The mask is selected by `MASK_SRC`, as follows:
  - `MASK_STATIC` gives `MASK_VAL`.
  - `MASK_DYN` gives `cmp_in`.
  - `MASK_RND1` gives `~cmp_in` shifted left by 1, with a 0 entering bit 0.
  - `MASK_RND2` gives `~cmp_in` shifted left by 2, with 0s entering bits 1:0.
- R6: `hit_inv` is 1 exactly when every unmasked bit of the new `acc_q` equals the inverse of the pattern bit.
- R7: With `AUTOCLR = CLR_MATCH`, the edge after any cycle showing `hit = 1` loads zero into `acc_q`, whatever the state of `en`. At that edge:
  - `hit` and `hit_inv` are computed from zero;
  - `ovf` and `unf` are 0.
- R8: With `AUTOCLR = CLR_NOMATCH`, the same clear happens on the edge after any cycle showing `hit = 0`.
- R9: `ovf` is set at an enabled, non-clearing edge when all of the following hold:
  - the previous `hit` was 1;
  - the new value matches neither the pattern nor its inverse;
  - `addend` is non-negative (bit W-1 = 0).
- R10: `unf` is set at an enabled, non-clearing edge when all of the following hold:
  - the previous `hit_inv` was 1;
  - the new value matches neither the pattern nor its inverse;
  - `addend` is negative (bit W-1 = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Update enable for the result register and its flags |
| addend | input | W | Two's-complement value added to the accumulator |
| cmp_in | input | W | Live pattern or mask source |
| acc_q | output | W | Registered accumulator value |
| hit | output | 1 | Masked match against the pattern |
| hit_inv | output | 1 | Masked match against the inverted pattern |
| ovf | output | 1 | Value left the pattern window moving upward |
| unf | output | 1 | Value left the inverted-pattern window moving downward |

## Verification
The inputs are sampled at one rising edge. The accumulator, both match flags, `ovf` and `unf` all show that edge's outcome straight after it. An auto-clear therefore appears one edge later than the flag that triggered it. `ovf` and `unf` depend on the flags from the preceding edge.

The driver task applies inputs on a falling edge. It pushes the predicted state after the following rising edge. The monitor compares that state at the next falling edge, so each result is read exactly one edge after its stimulus.

Five instances share the stimulus, so every pattern source, every mask source and every clear policy is seen under identical input streams.

// File: rtl/patmatch_pkg.sv
package patmatch_pkg;
  typedef enum logic {PAT_STATIC, PAT_DYN} pm_pat_src_e;
  typedef enum logic [1:0] {MASK_STATIC, MASK_DYN, MASK_RND1, MASK_RND2} pm_mask_src_e;
  typedef enum logic [1:0] {CLR_NONE, CLR_MATCH, CLR_NOMATCH} pm_autoclr_e;
endpackage

// File: rtl/pm_ref_sel.sv
module pm_ref_sel import patmatch_pkg::*; #(
  parameter int           W           = 48,
  parameter logic [W-1:0] PATTERN_VAL = '0,
  parameter logic [W-1:0] MASK_VAL    = '1,
  parameter pm_pat_src_e  PAT_SRC     = PAT_STATIC,
  parameter pm_mask_src_e MASK_SRC    = MASK_STATIC
) (
  input  logic [W-1:0] cmp_in,
  output logic [W-1:0] pat,
  output logic [W-1:0] mask
);
  // pattern source
  if (PAT_SRC == PAT_DYN) begin : g_pat_dyn
    assign pat = cmp_in;
  end else begin : g_pat_static
    assign pat = PATTERN_VAL;
  end

  // mask source; rounding masks shift zeros into the low end
  case (MASK_SRC)
    MASK_DYN:  begin : g_mask_dyn
      assign mask = cmp_in;
    end
    MASK_RND1: begin : g_mask_rnd1
      assign mask = {~cmp_in[W-2:0], 1'b0};
    end
    MASK_RND2: begin : g_mask_rnd2
      assign mask = {~cmp_in[W-3:0], 2'b00};
    end
    default:   begin : g_mask_static
      assign mask = MASK_VAL;
    end
  endcase

  if (PAT_SRC == PAT_STATIC && MASK_SRC == MASK_STATIC) begin : g_no_dyn
    logic unused_cmp;
    assign unused_cmp = ^cmp_in;
  end
endmodule

// File: rtl/pm_match.sv
module pm_match #(
  parameter int W = 48
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] mask,
  output logic         hit,
  output logic         hit_inv
);
  logic [W-1:0] diff;
  assign diff    = value ^ pat;
  assign hit     = &(~diff | mask);
  assign hit_inv = &(diff | mask);
endmodule

// File: rtl/pm_clear_ctl.sv
module pm_clear_ctl import patmatch_pkg::*; #(
  parameter pm_autoclr_e AUTOCLR = CLR_NONE
) (
  input  logic hit_q,
  output logic clr
);
  case (AUTOCLR)
    CLR_MATCH:   begin : g_clr_match
      assign clr = hit_q;
    end
    CLR_NOMATCH: begin : g_clr_nomatch
      assign clr = ~hit_q;
    end
    default:     begin : g_clr_none
      logic unused_hit;
      assign unused_hit = hit_q;
      assign clr = 1'b0;
    end
  endcase
endmodule

// File: rtl/patmatch_acc.sv
module patmatch_acc import patmatch_pkg::*; #(
  parameter int           W           = 48,
  parameter logic [W-1:0] PATTERN_VAL = '0,
  parameter logic [W-1:0] MASK_VAL    = '1,
  parameter pm_pat_src_e  PAT_SRC     = PAT_STATIC,
  parameter pm_mask_src_e MASK_SRC    = MASK_STATIC,
  parameter pm_autoclr_e  AUTOCLR     = CLR_NONE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] cmp_in,
  output logic [W-1:0] acc_q,
  output logic         hit,
  output logic         hit_inv,
  output logic         ovf,
  output logic         unf
);
  localparam int SIGN = W - 1;

  logic [W-1:0] pat, mask, sum_w, nxt;
  logic         clr, upd, up, hit_n, hinv_n, leave, ovf_n, unf_n;

  pm_ref_sel #(
    .W(W), .PATTERN_VAL(PATTERN_VAL), .MASK_VAL(MASK_VAL),
    .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC)
  ) u_ref_sel (
    .cmp_in(cmp_in), .pat(pat), .mask(mask)
  );

  pm_clear_ctl #(.AUTOCLR(AUTOCLR)) u_clear_ctl (
    .hit_q(hit), .clr(clr)
  );

  // next value: a pending clear wins over the sum
  assign sum_w = acc_q + addend;
  assign nxt   = clr ? '0 : sum_w;
  assign upd   = clr | en;
  assign up    = ~addend[SIGN];

  pm_match #(.W(W)) u_match (
    .value(nxt), .pat(pat), .mask(mask), .hit(hit_n), .hit_inv(hinv_n)
  );

  // leaving both windows; direction from the sign of the step
  assign leave = ~clr & ~hit_n & ~hinv_n;
  assign ovf_n = leave & hit & up;
  assign unf_n = leave & hit_inv & ~up;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      hit     <= 1'b0;
      hit_inv <= 1'b0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else if (upd) begin
      acc_q   <= nxt;
      hit     <= hit_n;
      hit_inv <= hinv_n;
      ovf     <= ovf_n;
      unf     <= unf_n;
    end
  end
endmodule

// File: rtl/pm_checker.sv
module pm_checker import patmatch_pkg::*; #(
  parameter int          W       = 48,
  parameter pm_autoclr_e AUTOCLR = CLR_NONE
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] addend,
  input logic [W-1:0] acc_q,
  input logic         hit,
  input logic         hit_inv,
  input logic         ovf,
  input logic         unf
);
  localparam bit CM = (AUTOCLR == CLR_MATCH);
  localparam bit CN = (AUTOCLR == CLR_NOMATCH);

  logic pend;
  assign pend = (CM && hit) || (CN && !hit);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !hit && !hit_inv && !ovf && !unf));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && !pend) |=> ($stable(acc_q) && $stable(hit) && $stable(hit_inv)
                        && $stable(ovf) && $stable(unf)));

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !pend) |=> (acc_q == $past(acc_q + addend)));

  p_clear_match_r7: assert property (@(posedge clk) disable iff (rst)
    (CM && hit) |=> (acc_q == '0 && !ovf && !unf));

  p_clear_nomatch_r8: assert property (@(posedge clk) disable iff (rst)
    (CN && !hit) |=> (acc_q == '0 && !ovf && !unf));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (!hit && !hit_inv && !unf));

  p_ovf_origin_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(hit));

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
    unf |-> (!hit && !hit_inv && !ovf));

  p_unf_origin_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(unf) |-> $past(hit_inv));
endmodule

bind patmatch_acc pm_checker #(.W(W), .AUTOCLR(AUTOCLR)) u_pm_checker (
  .clk(clk), .rst(rst), .en(en), .addend(addend), .acc_q(acc_q),
  .hit(hit), .hit_inv(hit_inv), .ovf(ovf), .unf(unf)
);

// File: tb/test_patmatch_acc.sv
module test_patmatch_acc;
  import patmatch_pkg::*;

  localparam int W = 48;
  localparam int N = 5;

  localparam logic [W-1:0] PV [N] = '{48'h10, 48'h0, 48'h0, 48'h0, 48'h4};
  localparam logic [W-1:0] MV [N] = '{48'h0, 48'hFF, 48'h0, 48'h0, 48'h0};
  localparam pm_pat_src_e  PS [N] = '{PAT_STATIC, PAT_STATIC, PAT_STATIC, PAT_DYN, PAT_STATIC};
  localparam pm_mask_src_e MS [N] = '{MASK_STATIC, MASK_STATIC, MASK_DYN, MASK_RND1, MASK_RND2};
  localparam pm_autoclr_e  AC [N] = '{CLR_MATCH, CLR_NONE, CLR_NOMATCH, CLR_NONE, CLR_NONE};

  typedef struct packed {
    logic         rs;
    logic [W-1:0] acc;
    logic         hit;
    logic         hinv;
    logic         ovf;
    logic         unf;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] addend = '0;
  logic [W-1:0] cmp_in = '1;

  logic [W-1:0] acc_o  [N];
  logic         hit_o  [N];
  logic         hinv_o [N];
  logic         ovf_o  [N];
  logic         unf_o  [N];

  for (genvar g = 0; g < N; g++) begin : g_dut
    patmatch_acc #(
      .W(W), .PATTERN_VAL(PV[g]), .MASK_VAL(MV[g]),
      .PAT_SRC(PS[g]), .MASK_SRC(MS[g]), .AUTOCLR(AC[g])
    ) i_patmatch_acc (
      .clk(clk), .rst(rst), .en(en), .addend(addend), .cmp_in(cmp_in),
      .acc_q(acc_o[g]), .hit(hit_o[g]), .hit_inv(hinv_o[g]),
      .ovf(ovf_o[g]), .unf(unf_o[g])
    );
  end

  always #2 clk = ~clk;

  exp_t         st [N];
  exp_t [N-1:0] sb [$];
  int           n_chk  = 0;
  int           n_fail = 0;
  bit           done   = 1'b0;

  // predicted state after one edge, written from the requirements
  function automatic exp_t model(int k, exp_t prev, logic r, logic e,
                                 logic [W-1:0] ad, logic [W-1:0] c);
    exp_t         n;
    logic [W-1:0] p, m, v;
    logic         clr;
    n = prev;
    n.rs = 1'b0;
    if (r) begin
      n = '0;
      n.rs = 1'b1;
      return n;
    end
    p = (PS[k] == PAT_DYN) ? c : PV[k];
    case (MS[k])
      MASK_DYN:  m = c;
      MASK_RND1: m = (~c) << 1;
      MASK_RND2: m = (~c) << 2;
      default:   m = MV[k];
    endcase
    clr = (AC[k] == CLR_MATCH && prev.hit) || (AC[k] == CLR_NOMATCH && !prev.hit);
    if (!clr && !e) return n;
    v = clr ? '0 : prev.acc + ad;
    n.acc  = v;
    n.hit  = ((v ^ p) & ~m) == '0;
    n.hinv = ((v ^ ~p) & ~m) == '0;
    n.ovf  = !clr && prev.hit  && !n.hit && !n.hinv && !ad[W-1];
    n.unf  = !clr && prev.hinv && !n.hit && !n.hinv &&  ad[W-1];
    return n;
  endfunction

  function automatic string itag(int k);
    case (k)
      0: return "R7 R3";
      1: return "R9 R10";
      2: return "R8 R5";
      3: return "R4 R5";
      default: return "R5 R6";
    endcase
  endfunction

  task automatic check(string tag, int k, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  // monitor: one edge after each stimulus, sampled on the falling edge
  always @(negedge clk) begin
    exp_t [N-1:0] row;
    if (sb.size() > 0) begin
      row = sb.pop_front();
      for (int k = 0; k < N; k++) begin
        string rt;
        rt = row[k].rs ? "R1 " : "";
        check({rt, "R2 acc ", itag(k)},      k, acc_o[k],       row[k].acc);
        check({rt, "R3 hit ", itag(k)},      k, W'(hit_o[k]),   W'(row[k].hit));
        check({rt, "R6 hit_inv ", itag(k)},  k, W'(hinv_o[k]),  W'(row[k].hinv));
        check({rt, "R9 ovf ", itag(k)},      k, W'(ovf_o[k]),   W'(row[k].ovf));
        check({rt, "R10 unf ", itag(k)},     k, W'(unf_o[k]),   W'(row[k].unf));
      end
    end
  end

  // driver: apply on falling edge, predict after the rising edge
  task automatic step(input logic r, input logic e,
                      input logic [W-1:0] ad, input logic [W-1:0] c);
    exp_t [N-1:0] row;
    rst = r; en = e; addend = ad; cmp_in = c;
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      st[k]  = model(k, st[k], r, e, ad, c);
      row[k] = st[k];
    end
    sb.push_back(row);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [31:0] x;
    logic [W-1:0] cv;
    for (int k = 0; k < N; k++) st[k] = '0;
    @(negedge clk);
    // R1: reset state
    step(1'b1, 1'b0, '0, '1);
    step(1'b1, 1'b0, '0, '1);
    // R2, R7: count by one until the terminal pattern, then clear with en low
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 48'd1, '1);
    step(1'b0, 1'b0, 48'd5, '1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 48'd7, '1);
    // R9: climb out of the low-byte window
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 48'd100, '1);
    // R10: after a fresh reset, fall out of the all-ones window
    step(1'b1, 1'b0, '0, '1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, -48'sd100, '1);
    // R8, R5: narrow the live mask so a non-match forces a clear
    step(1'b0, 1'b1, 48'd3, ~48'hFF);
    step(1'b0, 1'b1, 48'd3, ~48'hFF);
    step(1'b0, 1'b1, 48'd0, ~48'hFF);
    // R3, R4, R5, R6: mixed stream over several compare values
    x = 32'h1234_5678;
    for (int i = 0; i < 80; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      case (x[5:4])
        2'd0: cv = '1;
        2'd1: cv = ~48'hFF;
        2'd2: cv = 48'h3;
        default: cv = 48'h0000_0000_00F7;
      endcase
      step(x[9] & ~x[10] & ~x[11], x[0] | x[1], {{(W-10){x[15]}}, x[15:6]}, cv);
    end
    step(1'b0, 1'b0, '0, '1);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule